// File: doc/BRIEF.md
# Wrap serializer

This block is the transmit datapath of a 10-bit serial link. A source presents an already line-coded word (for example 8B/10B output) once per byte period. The block captures that word, then sends it out one bit per bit-clock cycle, least significant bit first. The model runs on a single bit-rate clock. A modulo-10 phase counter divides that clock to make the byte strobe, so exactly ten bit periods make up one word period.

A loopback control steers the serial stream. With loopback off, the stream drives the external serial output and the internal wrap output stays low. With loopback on, the stream goes only to the wrap output that feeds the local receiver, and the external output is held at logic 0. When loopback is switched off, the external output stays quiet until the next word boundary. It then resumes on a whole word.

The source watches `byte_stb` and keeps `word_in` steady across the clock edge that ends a strobe cycle. That edge is the capture edge.

Top module: `wrap_serializer`

## Requirements
- R1: While `rst` is sampled high at a rising edge, from the next cycle `ser_out` and `wrap_out` are 0 and `byte_stb` is 1. After reset, `ser_out` stays 0 until the first captured word reaches the shifter.
- R2: `byte_stb` is high for exactly one cycle in every ten. The first cycle after reset is a strobe cycle. `word_in` is captured at the rising edge that ends a strobe cycle.
- R3: A captured word leaves one bit per cycle in the order bit 0 through bit 9. Bit k is visible in the cycle after the (9+k)-th rising edge that follows the capture edge.
- R4: Transmit latency is constant. The first bit of a word becomes visible after the 9th rising edge that follows its capture edge, which is 10 falling edges after the strobe cycle in which the word was presented.
- R5: While loopback has been sampled low, `wrap_out` is 0. When the external output is not muted, `ser_out` carries the stream.
- R6: Once `loop_en` is sampled high at a rising edge, `ser_out` is 0 from the next cycle on, and `wrap_out` carries the stream.
- R7: After `loop_en` returns low, `wrap_out` goes to 0 from the next cycle. `ser_out` stays 0 until the next word-boundary edge, the edge that loads a new word into the shifter. It then resumes with bit 0 of that word.
- R8: The block applies no coding. Any 10-bit pattern, including all-ones, all-zeros and unbalanced words, is sent bit for bit.
- R9: A reset during operation discards the captured word and the word in flight. No bit of either reaches `ser_out` after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; the only clock of the block |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | WORD_W (10) | Pre-encoded parallel word, captured at the edge ending a strobe cycle |
| loop_en | input | 1 | Loopback enable: steers the stream to `wrap_out` and mutes `ser_out` |
| byte_stb | output | 1 | High for the one bit period whose closing edge captures `word_in` |
| ser_out | output | 1 | External serial output, LSB first, held at 0 during loopback |
| wrap_out | output | 1 | Internal serial wrap toward the receiver, active only in loopback |

## Verification
The bench goes after bit order and latency. A design that shifted MSB first, or loaded the shifter one edge early or late, would show the wrong bit at the sampled offsets and a first-bit delay other than ten falling edges. The bench also goes after loopback entry and exit. A design that freed the external output as soon as `loop_en` fell would leak the tail of a word that was sent in loopback. A design that kept `wrap_out` live would leak the stream onto the receiver path. Finally, the bench resets in the middle of an all-ones word. A design that kept the captured word or the in-flight word would emit stray ones after reset.

// File: rtl/ser_pkg.sv
package ser_pkg;

    // Output-select state: external mute flag and registered loopback mode.
    typedef struct packed {
        logic mute;
        logic lpk;
    } sel_state_t;

    // Width of a counter that spans 0 .. n-1.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ser_phase_ctr.sv
module ser_phase_ctr #(
    parameter int WORD_W = 10,
    parameter int CNT_W  = ser_pkg::cnt_width(WORD_W)
) (
    input  logic clk,
    input  logic rst,
    output logic byte_stb,
    output logic wrap_now
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (ctr_q.cnt == LAST) begin
            ctr_d.cnt = '0;
        end else begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
        byte_stb = (ctr_q.cnt == '0);
        wrap_now = (ctr_q.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // R2: a strobe cycle is never followed by another strobe cycle
    assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> !byte_stb);

    // R2: the word boundary is followed by the capture cycle
    assert_boundary_to_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        wrap_now |=> byte_stb);

endmodule

// File: rtl/ser_word_shifter.sv
module ser_word_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              bit_out
);
    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] sh;
    } shf_state_t;

    shf_state_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (capture) begin
            shf_d.hold = word_in;
        end
        if (load) begin
            shf_d.sh = shf_q.hold;
        end else begin
            shf_d.sh = {1'b0, shf_q.sh[WORD_W-1:1]};
        end
        bit_out = shf_q.sh[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    // R3: after a load, the first bit out is bit 0 of the held word
    assert_load_lsb_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (bit_out == $past(shf_q.hold[0])));

    // R3: between loads, the bit that was second in line comes out next
    assert_shift_order_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> (bit_out == $past(shf_q.sh[1])));

endmodule

// File: rtl/ser_out_sel.sv
module ser_out_sel (
    input  logic clk,
    input  logic rst,
    input  logic loop_en,
    input  logic boundary,
    input  logic bit_in,
    output logic ser_out,
    output logic wrap_out
);
    import ser_pkg::*;

    sel_state_t sel_d, sel_q;

    always_comb begin
        sel_d     = sel_q;
        sel_d.lpk = loop_en;
        if (loop_en) begin
            sel_d.mute = 1'b1;
        end else if (boundary) begin
            sel_d.mute = 1'b0;
        end
        ser_out  = sel_q.mute ? 1'b0 : bit_in;
        wrap_out = sel_q.lpk  ? bit_in : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    // R6: loopback sampled high forces the external output low next cycle
    assert_ext_hold_R6: assert property (@(posedge clk) disable iff (rst)
        loop_en |=> !ser_out);

    // R5: loopback sampled low keeps the wrap path idle next cycle
    assert_wrap_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !loop_en |=> !wrap_out);

    // R7: a muted output stays muted until a word boundary passes
    assert_resume_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_q.mute && !boundary) |=> !ser_out);

endmodule

// File: rtl/wrap_serializer.sv
module wrap_serializer #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              loop_en,
    output logic              byte_stb,
    output logic              ser_out,
    output logic              wrap_out
);
    localparam int CNT_W = ser_pkg::cnt_width(WORD_W);

    logic wrap_now;
    logic stream_bit;

    ser_phase_ctr #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .byte_stb (byte_stb),
        .wrap_now (wrap_now)
    );

    ser_word_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .capture (byte_stb),
        .load    (wrap_now),
        .word_in (word_in),
        .bit_out (stream_bit)
    );

    ser_out_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .loop_en  (loop_en),
        .boundary (wrap_now),
        .bit_in   (stream_bit),
        .ser_out  (ser_out),
        .wrap_out (wrap_out)
    );

    // R1: a sampled reset leaves both serial outputs low and the strobe high
    assert_reset_out_R1: assert property (@(posedge clk)
        rst |=> (!ser_out && !wrap_out && byte_stb));

endmodule

// File: tb/wrap_serializer_bench.sv
`timescale 1ns/1ps
module wrap_serializer_bench;
    localparam int W  = 10;
    localparam int NV = 12;

    // {loop_en, word}
    localparam logic [W:0] VEC [NV] = '{
        {1'b0, 10'h001}, {1'b0, 10'h3FF}, {1'b0, 10'h2AA}, {1'b0, 10'h155},
        {1'b1, 10'h0F3}, {1'b1, 10'h300}, {1'b0, 10'h07C}, {1'b0, 10'h2C5},
        {1'b1, 10'h1E1}, {1'b0, 10'h3C0}, {1'b0, 10'h000}, {1'b0, 10'h283}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         loop_en = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         byte_stb, ser_out, wrap_out;
    int           total = 0;
    int           bad = 0;

    always #10 clk = ~clk;

    wrap_serializer #(.WORD_W(W)) u_wrap_serializer (
        .clk      (clk),
        .rst      (rst),
        .word_in  (word_in),
        .loop_en  (loop_en),
        .byte_stb (byte_stb),
        .ser_out  (ser_out),
        .wrap_out (wrap_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W:0] prev;
        logic [W:0] cur;
        int         cnt;
        int         ones;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ser_out in reset", ser_out, 0);
        chk("R1 wrap_out in reset", wrap_out, 0);
        chk("R1 byte_stb in reset", byte_stb, 1);
        rst  = 1'b0;
        prev = '0;

        // table walk: at offset j of period i, bit j of word i-1 is visible
        for (int i = 0; i <= NV; i++) begin
            cur = (i < NV) ? VEC[i] : '0;
            for (int j = 0; j < W; j++) begin
                logic b, lpk, mute;
                if (j == 0) begin
                    word_in = cur[W-1:0];
                    loop_en = cur[W];
                end
                b    = prev[j];
                lpk  = (j == 0) ? prev[W] : cur[W];
                mute = (j == 0) ? prev[W] : (cur[W] | prev[W]);
                chk("R2 strobe phase", byte_stb, (j == 0) ? 1 : 0);
                if (!mute)
                    chk((i == 0) ? "R1 quiet before load" : "R3 R8 serial bit", ser_out, b);
                else if (j > 0 && prev[W] && !cur[W])
                    chk("R7 muted until boundary", ser_out, 0);
                else
                    chk("R6 external held", ser_out, 0);
                chk(lpk ? "R6 wrap stream" : "R5 wrap idle", wrap_out, lpk ? b : 0);
                @(negedge clk);
            end
            prev = cur;
        end

        // latency: word presented in a strobe cycle, count falling edges to first bit
        chk("R2 aligned to strobe", byte_stb, 1);
        word_in = 10'h001;
        loop_en = 1'b0;
        cnt = 0;
        @(negedge clk);
        cnt++;
        word_in = '0;
        while (ser_out !== 1'b1 && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk("R4 first-bit latency", cnt, 10);

        // strobe rate over 30 cycles
        ones = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (byte_stb) ones++;
        end
        chk("R2 strobe count", ones, 3);

        // reset mid-word with all ones in flight and captured
        while (byte_stb !== 1'b1) @(negedge clk);
        word_in = 10'h3FF;
        repeat (10) @(negedge clk);
        word_in = 10'h3FF;
        repeat (4) @(negedge clk);
        chk("R8 all-ones bit", ser_out, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 ser_out after reset", ser_out, 0);
        chk("R1 strobe after reset", byte_stb, 1);
        rst     = 1'b0;
        word_in = '0;
        ones = 0;
        for (int k = 0; k < 25; k++) begin
            if (ser_out !== 1'b0 || wrap_out !== 1'b0) ones++;
            @(negedge clk);
        end
        chk("R9 no stale bits", ones, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule